// File: doc/BRIEF.md
# Die identifier packing unit

This unit turns a set of manufacturing fields into one 64-bit die identifier. The fields are a Y coordinate, an X coordinate, a wafer number, a 32-bit lot code and a fab code. The lot code is read as five 6-bit digits. The unit folds these digits one per clock into a compact 26-bit value. Each fold step multiplies the running value by 36 and adds the next digit. The unit then places every field at a fixed bit position in the output word.

A caller pulses `start` for one cycle with the fields on the inputs. The unit captures the fields on that edge, so the inputs may change afterwards. It raises `done` for one cycle when the identifier is ready. The result stays on `die_id` until the next job completes. While a job is in progress, further `start` pulses are ignored.

Top module: `did_pack_top`

## Requirements
- R1: The lot digits are taken most significant first from lot code bits [29:24], [23:18], [17:12], [11:6] and [5:0]. Bits [31:30] of the lot code have no effect on the result.
- R2: The folded lot value starts at zero. Each step computes value × 36 + digit. After the five steps the value is reduced to its low 26 bits.
- R3: The identifier holds Y at bits [8:0], X at [17:9], the wafer number at [23:18], the 26-bit folded lot value at [49:24] and the fab code at [55:50].
- R4: Only the low 9 bits of each coordinate input are used, and only the low 6 bits of the wafer and fab inputs. Higher input bits do not affect the result.
- R5: Bits [63:56] of the identifier are always zero.
- R6: `start` is sampled on a rising clock edge while the unit is idle. `done` goes high after the fifth rising edge following that edge, and it stays high for exactly one cycle.
- R7: A `start` seen while a job is in progress is ignored. The running job produces its own result, and no extra `done` follows.
- R8: Digit values from 36 to 63 are accumulated as they are, with no range check or clamping.
- R9: The fields are captured at the accepted `start` edge, so later input changes do not affect the job. `die_id` holds its value between completions.
- R10: While reset is held low, `done` is 0 and `die_id` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job request, sampled when idle |
| y_in | input | 16 | Y coordinate; only the low 9 bits are used |
| x_in | input | 16 | X coordinate; only the low 9 bits are used |
| wafer_in | input | 16 | Wafer number; only the low 6 bits are used |
| lot_in | input | 32 | Lot code holding five 6-bit digits in bits [29:0] |
| fab_in | input | 16 | Fab code; only the low 6 bits are used |
| done | output | 1 | One-cycle pulse when `die_id` is updated |
| die_id | output | 64 | Packed die identifier |

## Verification
If `start` is accepted at rising edge k, the identifier and `done` appear after edge k+5. The bench drives inputs on falling edges. It samples outputs on the fifth falling edge after the accepting edge. It also confirms that `done` stayed low on the four falling edges before that, and that it is low again one falling edge later. Jobs that receive ignored `start` pulses are then watched for six more falling edges, to confirm that no second `done` appears. The hold check samples `die_id` several falling edges after a completion.

// File: rtl/did_pkg.sv
package did_pkg;
   // Default field geometry shared by the unit, its checker and its bench
   localparam int unsigned DEF_IN_W   = 16;
   localparam int unsigned DEF_YW     = 9;
   localparam int unsigned DEF_XW     = 9;
   localparam int unsigned DEF_WW     = 6;
   localparam int unsigned DEF_FW     = 6;
   localparam int unsigned DEF_DIGW   = 6;
   localparam int unsigned DEF_NDIG   = 5;
   localparam int unsigned DEF_RADIX  = 36;
   localparam int unsigned DEF_LOTW   = 26;
   localparam int unsigned DEF_CODE_W = 32;
   localparam int unsigned DEF_OUTW   = 64;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_FOLD = 1'b1
   } fold_phase_e;
endpackage

// File: rtl/did_digit_fold.sv
module did_digit_fold #(
   parameter int unsigned DIGW  = did_pkg::DEF_DIGW,
   parameter int unsigned NDIG  = did_pkg::DEF_NDIG,
   parameter int unsigned RADIX = did_pkg::DEF_RADIX,
   parameter int unsigned ACCW  = did_pkg::DEF_LOTW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [NDIG*DIGW-1:0] code,
   output logic                 busy,
   output logic                 last,
   output logic [ACCW-1:0]      acc_next
);
   import did_pkg::*;

   localparam int unsigned SHW  = NDIG * DIGW;
   localparam int unsigned IDXW = (NDIG > 1) ? $clog2(NDIG) : 1;
   localparam bit RADIX_POW2    = ((RADIX & (RADIX - 1)) == 0);
   localparam int unsigned RSH  = (RADIX > 1) ? $clog2(RADIX) : 0;

   if (NDIG < 2) begin : g_bad_ndig
      $error("did_digit_fold: NDIG must be at least 2");
   end
   if (RADIX < 2) begin : g_bad_radix
      $error("did_digit_fold: RADIX must be at least 2");
   end
   if (DIGW > ACCW) begin : g_bad_digw
      $error("did_digit_fold: DIGW wider than accumulator");
   end

   fold_phase_e       phase_q;
   logic [SHW-1:0]    sh_q;
   logic [ACCW-1:0]   acc_q;
   logic [IDXW-1:0]   idx_q;
   logic [ACCW-1:0]   scaled;
   logic [DIGW-1:0]   digit;

   assign digit = sh_q[SHW-1 -: DIGW];

   // Scaling by the radix: a shift when it is a power of two, a product otherwise
   if (RADIX_POW2) begin : g_scale_shift
      assign scaled = acc_q << RSH;
   end else begin : g_scale_mul
      assign scaled = acc_q * ACCW'(RADIX);
   end

   assign acc_next = scaled + ACCW'(digit);
   assign busy     = (phase_q == PH_FOLD);
   assign last     = busy && (idx_q == IDXW'(NDIG - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         sh_q    <= '0;
         acc_q   <= '0;
         idx_q   <= '0;
      end else if (load && !busy) begin
         phase_q <= PH_FOLD;
         sh_q    <= code;
         acc_q   <= '0;
         idx_q   <= '0;
      end else if (busy) begin
         acc_q <= acc_next;
         sh_q  <= sh_q << DIGW;
         idx_q <= idx_q + 1'b1;
         if (last) begin
            phase_q <= PH_IDLE;
         end
      end
   end
endmodule

// File: rtl/did_field_pack.sv
module did_field_pack #(
   parameter int unsigned YW   = did_pkg::DEF_YW,
   parameter int unsigned XW   = did_pkg::DEF_XW,
   parameter int unsigned WW   = did_pkg::DEF_WW,
   parameter int unsigned LOTW = did_pkg::DEF_LOTW,
   parameter int unsigned FW   = did_pkg::DEF_FW,
   parameter int unsigned OUTW = did_pkg::DEF_OUTW
) (
   input  logic [YW-1:0]   y,
   input  logic [XW-1:0]   x,
   input  logic [WW-1:0]   wafer,
   input  logic [LOTW-1:0] lot,
   input  logic [FW-1:0]   fab,
   output logic [OUTW-1:0] word
);
   localparam int unsigned X_LSB   = YW;
   localparam int unsigned W_LSB   = X_LSB + XW;
   localparam int unsigned L_LSB   = W_LSB + WW;
   localparam int unsigned F_LSB   = L_LSB + LOTW;
   localparam int unsigned USED    = F_LSB + FW;

   if (USED > OUTW) begin : g_bad_outw
      $error("did_field_pack: fields do not fit in OUTW");
   end

   logic [USED-1:0] body;
   assign body = {fab, lot, wafer, x, y};

   if (USED < OUTW) begin : g_pad
      assign word = {{(OUTW - USED){1'b0}}, body};
   end else begin : g_exact
      assign word = body;
   end
endmodule

// File: rtl/did_pack_top.sv
module did_pack_top #(
   parameter int unsigned IN_W   = did_pkg::DEF_IN_W,
   parameter int unsigned YW     = did_pkg::DEF_YW,
   parameter int unsigned XW     = did_pkg::DEF_XW,
   parameter int unsigned WW     = did_pkg::DEF_WW,
   parameter int unsigned FW     = did_pkg::DEF_FW,
   parameter int unsigned DIGW   = did_pkg::DEF_DIGW,
   parameter int unsigned NDIG   = did_pkg::DEF_NDIG,
   parameter int unsigned RADIX  = did_pkg::DEF_RADIX,
   parameter int unsigned LOTW   = did_pkg::DEF_LOTW,
   parameter int unsigned CODE_W = did_pkg::DEF_CODE_W,
   parameter int unsigned OUTW   = did_pkg::DEF_OUTW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IN_W-1:0]   y_in,
   input  logic [IN_W-1:0]   x_in,
   input  logic [IN_W-1:0]   wafer_in,
   input  logic [CODE_W-1:0] lot_in,
   input  logic [IN_W-1:0]   fab_in,
   output logic              done,
   output logic [OUTW-1:0]   die_id
);
   localparam int unsigned DIG_BITS = NDIG * DIGW;

   if (YW > IN_W || XW > IN_W || WW > IN_W || FW > IN_W) begin : g_bad_in
      $error("did_pack_top: a field is wider than IN_W");
   end
   if (DIG_BITS > CODE_W) begin : g_bad_code
      $error("did_pack_top: digits do not fit in the lot code");
   end

   logic              busy;
   logic              last;
   logic              accept;
   logic [LOTW-1:0]   lot_fold;
   logic [YW-1:0]     y_q;
   logic [XW-1:0]     x_q;
   logic [WW-1:0]     w_q;
   logic [FW-1:0]     f_q;
   logic [OUTW-1:0]   packed_word;
   logic [OUTW-1:0]   die_q;
   logic              done_q;

   assign accept = start && !busy;

   // Field capture, cut to width on the way in
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_q <= '0;
         x_q <= '0;
         w_q <= '0;
         f_q <= '0;
      end else if (accept) begin
         y_q <= y_in[YW-1:0];
         x_q <= x_in[XW-1:0];
         w_q <= wafer_in[WW-1:0];
         f_q <= fab_in[FW-1:0];
      end
   end

   did_digit_fold #(
      .DIGW (DIGW),
      .NDIG (NDIG),
      .RADIX(RADIX),
      .ACCW (LOTW)
   ) u_fold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .code    (lot_in[DIG_BITS-1:0]),
      .busy    (busy),
      .last    (last),
      .acc_next(lot_fold)
   );

   did_field_pack #(
      .YW  (YW),
      .XW  (XW),
      .WW  (WW),
      .LOTW(LOTW),
      .FW  (FW),
      .OUTW(OUTW)
   ) u_pack (
      .y    (y_q),
      .x    (x_q),
      .wafer(w_q),
      .lot  (lot_fold),
      .fab  (f_q),
      .word (packed_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         die_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= last;
         if (last) begin
            die_q <= packed_word;
         end
      end
   end

   assign done   = done_q;
   assign die_id = die_q;
endmodule

// File: rtl/did_pack_chk.sv
module did_pack_chk #(
   parameter int unsigned IN_W = did_pkg::DEF_IN_W,
   parameter int unsigned YW   = did_pkg::DEF_YW,
   parameter int unsigned FW   = did_pkg::DEF_FW,
   parameter int unsigned NDIG = did_pkg::DEF_NDIG,
   parameter int unsigned FLSB = 50,
   parameter int unsigned OUTW = did_pkg::DEF_OUTW
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [IN_W-1:0] y_in,
   input logic [IN_W-1:0] fab_in,
   input logic            done,
   input logic [OUTW-1:0] die_id
);
   localparam int unsigned CW = $clog2(NDIG + 1);

   logic [CW-1:0]   cnt;
   logic [YW-1:0]   y_cap;
   logic [FW-1:0]   f_cap;

   // Independent job tracker: 1 after the accepting edge, NDIG one cycle before done
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         y_cap <= '0;
         f_cap <= '0;
      end else if (cnt == '0) begin
         if (start) begin
            cnt   <= CW'(1);
            y_cap <= y_in[YW-1:0];
            f_cap <= fab_in[FW-1:0];
         end
      end else if (cnt == CW'(NDIG)) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(NDIG)) |=> done);

   a_r7_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(cnt) == CW'(NDIG)));

   a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(die_id));

   a_r3_y_field: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (die_id[YW-1:0] == y_cap));

   a_r4_fab_field: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (die_id[FLSB +: FW] == f_cap));
endmodule

bind did_pack_top did_pack_chk #(
   .IN_W(IN_W),
   .YW  (YW),
   .FW  (FW),
   .NDIG(NDIG),
   .FLSB(YW + XW + WW + LOTW),
   .OUTW(OUTW)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .y_in  (y_in),
   .fab_in(fab_in),
   .done  (done),
   .die_id(die_id)
);

// File: tb/sim_did_pack_top.sv
module sim_did_pack_top;
   localparam int unsigned CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] y_in = '0;
   logic [15:0] x_in = '0;
   logic [15:0] wafer_in = '0;
   logic [31:0] lot_in = '0;
   logic [15:0] fab_in = '0;
   logic        done;
   logic [63:0] die_id;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   did_pack_top u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .y_in    (y_in),
      .x_in    (x_in),
      .wafer_in(wafer_in),
      .lot_in  (lot_in),
      .fab_in  (fab_in),
      .done    (done),
      .die_id  (die_id)
   );

   // Expected identifier computed arithmetically from the requirements
   function automatic logic [63:0] model(input logic [15:0] y, input logic [15:0] x,
                                         input logic [15:0] w, input logic [31:0] lot,
                                         input logic [15:0] f);
      logic [63:0] acc;
      acc = 64'd0;
      for (int i = 0; i < 5; i++) begin
         acc = acc * 64'd36 + ((64'(lot) >> (24 - 6 * i)) & 64'd63);
      end
      acc = acc & 64'h3FF_FFFF;
      return (64'(y) & 64'h1FF) | ((64'(x) & 64'h1FF) << 9) |
             ((64'(w) & 64'h3F) << 18) | (acc << 24) | ((64'(f) & 64'h3F) << 50);
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] got,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   // One job: start accepted at the next edge, result checked five edges later
   task automatic run_one(input logic [15:0] y, input logic [15:0] x, input logic [15:0] w,
                          input logic [31:0] lot, input logic [15:0] f, input bit poke,
                          input string tag, output logic [63:0] res);
      logic [63:0] exp;
      bit early;
      exp = model(y, x, w, lot, f);
      early = 1'b0;
      @(negedge clk);
      start = 1'b1; y_in = y; x_in = x; wafer_in = w; lot_in = lot; fab_in = f;
      @(negedge clk);
      start = 1'b0;
      y_in = 16'($urandom); x_in = 16'($urandom); wafer_in = 16'($urandom);
      lot_in = $urandom; fab_in = 16'($urandom);
      for (int c = 0; c < 4; c++) begin
         start = poke && (c != 0);
         @(negedge clk);
         if (done) early = 1'b1;
      end
      start = 1'b0;
      @(negedge clk);
      check(done && !early, "R6 done timing", {63'd0, done}, 64'd1);
      check(die_id == exp, tag, die_id, exp);
      check(die_id[63:56] == 8'd0, "R5 top byte", die_id, exp);
      res = die_id;
      @(negedge clk);
      check(!done, "R6 pulse width", {63'd0, done}, 64'd0);
      if (poke) begin
         bit extra;
         extra = 1'b0;
         for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (done) extra = 1'b1;
         end
         check(!extra && die_id == exp, "R7 busy start ignored", die_id, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] r_a;
      logic [63:0] r_b;
      logic [63:0] held;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(!done && die_id == 64'd0, "R10 reset", die_id, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: all-zero job and a known value (digits 1,2,3,4,5)
      run_one(16'd0, 16'd0, 16'd0, 32'd0, 16'd0, 1'b0, "R2 zero", r_a);
      run_one(16'd5, 16'd7, 16'd3, {2'b00, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5}, 16'd9, 1'b0,
              "R2 known digits", r_a);
      // R8: digits above 35, R2 truncation with all digits at 63
      run_one(16'h1FF, 16'h1FF, 16'h3F, 32'hFFFF_FFFF, 16'h3F, 1'b0,
              "R8 R2 max digits", r_a);
      run_one(16'd1, 16'd2, 16'd4, {2'b00, {5{6'd35}}}, 16'd8, 1'b0, "R2 digit 35", r_a);
      // R4: upper input bits set must be ignored
      run_one(16'hFE01, 16'hAA02, 16'hFFC3, 32'h1234_5678, 16'hFFC1, 1'b0,
              "R4 input masking", r_a);
      // R1: bits [31:30] have no effect
      run_one(16'd11, 16'd22, 16'd33, 32'h0ABC_DEF1, 16'd44, 1'b0, "R1 base", r_a);
      run_one(16'd11, 16'd22, 16'd33, 32'hCABC_DEF1, 16'd44, 1'b0, "R1 high bits", r_b);
      check(r_a == r_b, "R1 bits 31:30 ignored", r_b, r_a);
      // R3: each field alone lands at its position
      run_one(16'h155, 16'd0, 16'd0, 32'd0, 16'd0, 1'b0, "R3 y alone", r_a);
      run_one(16'd0, 16'h0AA, 16'd0, 32'd0, 16'd0, 1'b0, "R3 x alone", r_a);
      run_one(16'd0, 16'd0, 16'h2A, 32'd0, 16'd0, 1'b0, "R3 wafer alone", r_a);
      run_one(16'd0, 16'd0, 16'd0, 32'd0, 16'h15, 1'b0, "R3 fab alone", r_a);
      // R7: start pulses during a job
      run_one(16'd100, 16'd200, 16'd30, 32'h2468_ACE0, 16'd50, 1'b1, "R7 poked job", r_a);
      // R9: result held after completion
      held = die_id;
      repeat (4) @(negedge clk);
      check(die_id == held, "R9 hold", die_id, held);

      // Sweep every digit value in every digit position (R1 R2 R8)
      for (int pos = 0; pos < 5; pos++) begin
         for (int v = 0; v < 64; v++) begin
            logic [31:0] lot;
            int sh;
            sh = 24 - 6 * pos;
            lot = ($urandom & ~(32'd63 << sh)) | (32'(v) << sh);
            run_one(16'($urandom), 16'($urandom), 16'($urandom), lot, 16'($urandom),
                    (v % 16) == 5, "R1 R2 R8 digit sweep", r_a);
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule